// File: doc/BRIEF.md
# CPU interrupt and reset front-end

This block sits between the control pins of an 8-bit processor core and the core itself. It merges two active-low peripheral interrupt lines into one request and passes that request through a two-stage delay. It catches falling edges on the non-maskable interrupt pin and holds them in a latch until the core acknowledges. It forwards the ready pin. It lets the core advance only while the bus-available input grants the bus. It turns set-overflow requests into delayed single-cycle pulses. It also counts the cycles in which the core was held off the bus.

After reset the block owns the memory read port for two cycles. It reads the low byte of the start vector, then the high byte at the next address. On the third cycle it presents the assembled 16-bit value with a one-cycle load strobe, and only then does it let the core step.

Top module: `cpu_ctrl_frontend`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `irq`, `nmi_latch`, `set_overflow`, `pc_load` and `step_enable` are 0, `lag_count` is 0, and the vector fetch restarts from its first read.
- R2: In the cycle after the last reset edge, `mem_rd` is 1 with `mem_addr` = 0xFFFC. In the next cycle `mem_rd` is 1 with `mem_addr` = 0xFFFD. In the cycle after that, `pc_load` is 1 for exactly one cycle and `pc_value` = (byte read at 0xFFFD) * 256 + (byte read at 0xFFFC). Each byte is sampled from `mem_rdata` at the clock edge that ends its read cycle.
- R3: `irq` is 1 if `irq_a_n` or `irq_b_n` was 0 at the clock edge two edges earlier, and 0 if both were 1. A pin change therefore appears after the second clock edge.
- R4: `nmi_latch` is set at a clock edge where `aec` is 1 and the pin level registered at the previous edge shows `nmi_n` low, while the level recorded at the last edge with `aec` high showed it high. The recorded level is only updated at edges with `aec` high.
- R5: Once set, `nmi_latch` stays 1 until an edge with `nmi_ack` = 1 clears it. A new edge at that same clock edge wins, and the latch stays 1. A pin that stays low does not set the latch again.
- R6: `step_enable` is 1 only when `aec` is 1 and the vector fetch has finished.
- R7: `lag_count` increments by one, wrapping, at every clock edge after the vector fetch where `aec` is 0. Otherwise it holds.
- R8: `rdy` equals `rdy_pin` in every cycle, whatever the level of `aec`.
- R9: If `so_req` is 1 at a clock edge, `set_overflow` is 1 for one cycle, starting after the clock edge SO_DEPTH-1 edges later (default: the next edge). Back-to-back requests give back-to-back pulses.
- R10: A low pulse on `nmi_n` that starts and ends while `aec` is 0 is ignored, and `nmi_latch` stays 0 after the bus is granted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_a_n | input | 1 | First peripheral interrupt, active low |
| irq_b_n | input | 1 | Second peripheral interrupt, active low |
| nmi_n | input | 1 | Non-maskable interrupt pin, active low |
| nmi_ack | input | 1 | Core clears the NMI latch |
| aec | input | 1 | Bus available to the core |
| rdy_pin | input | 1 | Ready pin |
| so_req | input | 1 | Set-overflow request |
| mem_rdata | input | DATA_W | Read data for the vector fetch |
| mem_rd | output | 1 | Vector read request |
| mem_addr | output | 2*DATA_W | Vector read address |
| irq | output | 1 | Delayed combined interrupt request to core |
| nmi_latch | output | 1 | Pending non-maskable interrupt |
| rdy | output | 1 | Ready to core |
| step_enable | output | 1 | Core may execute this cycle |
| set_overflow | output | 1 | Set-overflow pulse to core |
| pc_load | output | 1 | Load start address strobe |
| pc_value | output | 2*DATA_W | Start address |
| lag_count | output | LAG_W | Cycles the core was held off the bus |

## Verification
The assertions assume that every pin is already synchronous to `clk`. They also assume that `mem_rdata` holds the addressed byte in the same cycle that `mem_rd` and `mem_addr` present it, because the fetch samples it at the closing edge. The bench changes every input only on the falling clock edge. Its memory model answers combinationally from `mem_addr`, with vector bytes that it alters between resets. The timing properties on `irq` and on the NMI set condition hold only once two edges have passed since reset, so the checker waits for that before it applies them.

// File: rtl/cpu_fe_pkg.sv
package cpu_fe_pkg;

    typedef enum logic [1:0] {
        VF_LO   = 2'd0,
        VF_HI   = 2'd1,
        VF_LOAD = 2'd2,
        VF_RUN  = 2'd3
    } vf_state_e;

    typedef struct packed {
        logic seen;   // level registered at the previous edge
        logic held;   // level recorded at the last granted edge
    } nmi_hist_t;

    function automatic logic any_low(input logic a_n, input logic b_n);
        return !(a_n && b_n);
    endfunction

    function automatic logic falling_seen(input nmi_hist_t h);
        return h.seen && !h.held;
    endfunction

endpackage

// File: rtl/fe_vector_fetch.sv
module fe_vector_fetch
    import cpu_fe_pkg::*;
#(
    parameter int                    DATA_W   = 8,
    parameter logic [2*DATA_W-1:0]   VEC_BASE = 16'hFFFC
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  mem_rd,
    output logic [2*DATA_W-1:0]   mem_addr,
    output logic                  pc_load,
    output logic [2*DATA_W-1:0]   pc_value,
    output logic                  running
);
    localparam int ADDR_W = 2 * DATA_W;
    localparam logic [ADDR_W-1:0] VEC_HI = ADDR_W'(VEC_BASE + 1);

    vf_state_e         state_q;
    logic [DATA_W-1:0] lo_q;
    logic [ADDR_W-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= VF_LO;
            lo_q    <= '0;
            pc_q    <= '0;
        end else begin
            unique case (state_q)
                VF_LO: begin
                    lo_q    <= mem_rdata;
                    state_q <= VF_HI;
                end
                VF_HI: begin
                    pc_q    <= {mem_rdata, lo_q};
                    state_q <= VF_LOAD;
                end
                VF_LOAD: state_q <= VF_RUN;
                default: state_q <= VF_RUN;
            endcase
        end
    end

    assign mem_rd   = (state_q == VF_LO) || (state_q == VF_HI);
    assign mem_addr = (state_q == VF_HI) ? VEC_HI : VEC_BASE;
    assign pc_load  = (state_q == VF_LOAD);
    assign pc_value = pc_q;
    assign running  = (state_q == VF_RUN);
endmodule

// File: rtl/fe_int_cond.sv
module fe_int_cond
    import cpu_fe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic irq_a_n,
    input  logic irq_b_n,
    input  logic nmi_n,
    input  logic nmi_ack,
    input  logic aec,
    output logic irq,
    output logic nmi_latch
);
    logic [1:0] irq_hist_q;
    nmi_hist_t  nmi_hist_q;
    logic       nmi_latch_q;
    logic       nmi_edge;

    assign nmi_edge = aec && falling_seen(nmi_hist_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_hist_q  <= '0;
            nmi_hist_q  <= '0;
            nmi_latch_q <= 1'b0;
        end else begin
            irq_hist_q      <= {any_low(irq_a_n, irq_b_n), irq_hist_q[1]};
            nmi_hist_q.seen <= !nmi_n;
            if (aec) begin
                nmi_hist_q.held <= nmi_hist_q.seen;
            end
            nmi_latch_q <= nmi_edge || (nmi_latch_q && !nmi_ack);
        end
    end

    assign irq       = irq_hist_q[0];
    assign nmi_latch = nmi_latch_q;
endmodule

// File: rtl/fe_overflow_pipe.sv
module fe_overflow_pipe #(
    parameter int SO_DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic so_req,
    output logic set_overflow
);
    logic [SO_DEPTH-1:0] sreg_q;

    generate
        if (SO_DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sreg_q <= '0;
                else     sreg_q <= so_req;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sreg_q <= '0;
                else     sreg_q <= {so_req, sreg_q[SO_DEPTH-1:1]};
            end
        end
    endgenerate

    assign set_overflow = sreg_q[0];
endmodule

// File: rtl/cpu_ctrl_frontend.sv
module cpu_ctrl_frontend
    import cpu_fe_pkg::*;
#(
    parameter int                  DATA_W   = 8,
    parameter int                  LAG_W    = 16,
    parameter int                  SO_DEPTH = 2,
    parameter logic [2*DATA_W-1:0] VEC_BASE = 16'hFFFC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                irq_a_n,
    input  logic                irq_b_n,
    input  logic                nmi_n,
    input  logic                nmi_ack,
    input  logic                aec,
    input  logic                rdy_pin,
    input  logic                so_req,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                mem_rd,
    output logic [2*DATA_W-1:0] mem_addr,
    output logic                irq,
    output logic                nmi_latch,
    output logic                rdy,
    output logic                step_enable,
    output logic                set_overflow,
    output logic                pc_load,
    output logic [2*DATA_W-1:0] pc_value,
    output logic [LAG_W-1:0]    lag_count
);
    logic             running;
    logic [LAG_W-1:0] lag_q;

    fe_vector_fetch #(.DATA_W(DATA_W), .VEC_BASE(VEC_BASE)) u_vec (
        .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .pc_load(pc_load), .pc_value(pc_value),
        .running(running)
    );

    fe_int_cond u_int (
        .clk(clk), .rst(rst), .irq_a_n(irq_a_n), .irq_b_n(irq_b_n),
        .nmi_n(nmi_n), .nmi_ack(nmi_ack), .aec(aec),
        .irq(irq), .nmi_latch(nmi_latch)
    );

    fe_overflow_pipe #(.SO_DEPTH(SO_DEPTH)) u_so (
        .clk(clk), .rst(rst), .so_req(so_req), .set_overflow(set_overflow)
    );

    always_ff @(posedge clk) begin
        if (rst)                  lag_q <= '0;
        else if (running && !aec) lag_q <= lag_q + 1'b1;
    end

    assign lag_count   = lag_q;
    assign step_enable = running && aec;
    assign rdy         = rdy_pin;
endmodule

// File: rtl/cpu_ctrl_frontend_chk.sv
module cpu_ctrl_frontend_chk #(
    parameter int                  DATA_W   = 8,
    parameter int                  LAG_W    = 16,
    parameter logic [2*DATA_W-1:0] VEC_BASE = 16'hFFFC
) (
    input logic                clk,
    input logic                rst,
    input logic                irq_a_n,
    input logic                irq_b_n,
    input logic                nmi_n,
    input logic                nmi_ack,
    input logic                aec,
    input logic                mem_rd,
    input logic [2*DATA_W-1:0] mem_addr,
    input logic                irq,
    input logic                nmi_latch,
    input logic                step_enable,
    input logic                pc_load,
    input logic [LAG_W-1:0]    lag_count,
    input logic                running
);
    localparam logic [2*DATA_W-1:0] VEC_HI = (2*DATA_W)'(VEC_BASE + 1);

    logic [1:0] since_q;
    always_ff @(posedge clk) begin
        if (rst)                 since_q <= 2'd0;
        else if (since_q != 2'd3) since_q <= since_q + 2'd1;
    end

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && !nmi_latch && !pc_load && lag_count == '0));

    a_r2_vector_order: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> ($past(mem_rd) && $past(mem_addr) == VEC_HI));

    a_r2_single_load: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !pc_load);

    a_r3_irq_delay: assert property (@(posedge clk) disable iff (rst)
        (since_q >= 2'd2) |-> (irq == $past(!(irq_a_n && irq_b_n), 2)));

    a_r4_nmi_granted_edge: assert property (@(posedge clk) disable iff (rst)
        ((since_q >= 2'd2) && $rose(nmi_latch)) |-> ($past(aec) && !$past(nmi_n, 2)));

    a_r5_nmi_hold: assert property (@(posedge clk) disable iff (rst)
        (nmi_latch && !nmi_ack) |=> nmi_latch);

    a_r6_step_gate: assert property (@(posedge clk) disable iff (rst)
        step_enable |-> (aec && running));

    a_r7_lag_inc: assert property (@(posedge clk) disable iff (rst)
        (running && !aec) |=> (lag_count == $past(lag_count) + 1'b1));

    a_r7_lag_hold: assert property (@(posedge clk) disable iff (rst)
        !(running && !aec) |=> $stable(lag_count));
endmodule

bind cpu_ctrl_frontend cpu_ctrl_frontend_chk #(
    .DATA_W(DATA_W), .LAG_W(LAG_W), .VEC_BASE(VEC_BASE)
) u_chk (
    .clk(clk), .rst(rst), .irq_a_n(irq_a_n), .irq_b_n(irq_b_n),
    .nmi_n(nmi_n), .nmi_ack(nmi_ack), .aec(aec), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .irq(irq), .nmi_latch(nmi_latch),
    .step_enable(step_enable), .pc_load(pc_load), .lag_count(lag_count),
    .running(running)
);

// File: tb/tb_cpu_ctrl_frontend.sv
module tb_cpu_ctrl_frontend;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2 * DATA_W;
    localparam int LAG_W    = 16;
    localparam int SO_DEPTH = 2;
    localparam logic [ADDR_W-1:0] VEC = 16'hFFFC;

    logic clk = 1'b0;
    logic rst, irq_a_n, irq_b_n, nmi_n, nmi_ack, aec, rdy_pin, so_req;
    logic [DATA_W-1:0] mem_rdata;
    logic mem_rd, irq, nmi_latch, rdy, step_enable, set_overflow, pc_load;
    logic [ADDR_W-1:0] mem_addr, pc_value;
    logic [LAG_W-1:0] lag_count;
    logic [DATA_W-1:0] vlo, vhi;

    always #4 clk = ~clk;

    cpu_ctrl_frontend #(.DATA_W(DATA_W), .LAG_W(LAG_W), .SO_DEPTH(SO_DEPTH), .VEC_BASE(VEC)) dut (
        .clk(clk), .rst(rst), .irq_a_n(irq_a_n), .irq_b_n(irq_b_n), .nmi_n(nmi_n),
        .nmi_ack(nmi_ack), .aec(aec), .rdy_pin(rdy_pin), .so_req(so_req),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr), .irq(irq),
        .nmi_latch(nmi_latch), .rdy(rdy), .step_enable(step_enable),
        .set_overflow(set_overflow), .pc_load(pc_load), .pc_value(pc_value),
        .lag_count(lag_count)
    );

    assign mem_rdata = !mem_rd ? 8'h00 :
                       (mem_addr == VEC) ? vlo :
                       (mem_addr == VEC + 16'd1) ? vhi : 8'hEE;

    int checks = 0;
    int failures = 0;

    // reference model state
    int   m_state;
    logic [DATA_W-1:0] m_lo;
    logic [ADDR_W-1:0] m_pc;
    bit   irq_q[$];
    bit   so_q[$];
    bit   nmi_q[$];
    bit   m_prev, m_latch;
    int   m_lag;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit sync, run_before, setn;
        if (rst) begin
            m_state = 0; m_lo = '0; m_pc = '0;
            irq_q.delete(); so_q.delete(); nmi_q.delete();
            m_prev = 0; m_latch = 0; m_lag = 0;
        end else begin
            sync = (nmi_q.size() > 0) ? nmi_q[$] : 1'b0;
            run_before = (m_state == 3);
            case (m_state)
                0: begin m_lo = vlo; m_state = 1; end
                1: begin m_pc = {vhi, m_lo}; m_state = 2; end
                default: m_state = 3;
            endcase
            if (run_before && !aec) m_lag = (m_lag + 1) % (1 << LAG_W);
            setn = aec && sync && !m_prev;
            if (aec) m_prev = sync;
            if (setn) m_latch = 1;
            else if (nmi_ack) m_latch = 0;
            irq_q.push_back(!(irq_a_n && irq_b_n));
            nmi_q.push_back(!nmi_n);
            so_q.push_back(so_req);
            while (irq_q.size() > 4) void'(irq_q.pop_front());
            while (nmi_q.size() > 4) void'(nmi_q.pop_front());
            while (so_q.size() > SO_DEPTH + 2) void'(so_q.pop_front());
        end
    endtask

    task automatic compare_all();
        bit e_irq, e_so;
        e_irq = (irq_q.size() >= 2) ? irq_q[$-1] : 1'b0;
        e_so  = (so_q.size() >= SO_DEPTH) ? so_q[$-(SO_DEPTH-1)] : 1'b0;
        chk(irq === e_irq, "R3", "irq", irq, e_irq);
        chk(nmi_latch === m_latch, "R4", "nmi_latch", nmi_latch, m_latch);
        chk(set_overflow === e_so, "R9", "set_overflow", set_overflow, e_so);
        chk(lag_count === LAG_W'(m_lag), "R7", "lag_count", lag_count, m_lag);
        chk(rdy === rdy_pin, "R8", "rdy", rdy, rdy_pin);
        chk(step_enable === (m_state == 3 && aec), "R6", "step_enable", step_enable, (m_state == 3 && aec));
        chk(mem_rd === (m_state < 2), "R2", "mem_rd", mem_rd, (m_state < 2));
        if (m_state < 2)
            chk(mem_addr === VEC + ADDR_W'(m_state), "R2", "mem_addr", mem_addr, VEC + ADDR_W'(m_state));
        chk(pc_load === (m_state == 2), "R2", "pc_load", pc_load, (m_state == 2));
        if (m_state == 2)
            chk(pc_value === m_pc, "R2", "pc_value", pc_value, m_pc);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1; irq_a_n = 1; irq_b_n = 1; nmi_n = 1; nmi_ack = 0;
        aec = 1; rdy_pin = 1; so_req = 0; vlo = 8'h3A; vhi = 8'hC5;
        ticks(3);
        // R1 reset state
        chk(irq == 0 && nmi_latch == 0 && set_overflow == 0, "R1", "int outputs", {irq, nmi_latch, set_overflow}, 0);
        chk(lag_count == 0 && step_enable == 0 && pc_load == 0, "R1", "lag/step/load", lag_count, 0);
        rst = 0;
        #1;
        // R2 vector fetch sequence
        chk(mem_rd == 1 && mem_addr == 16'hFFFC, "R2", "low read", mem_addr, 16'hFFFC);
        tick();
        chk(mem_rd == 1 && mem_addr == 16'hFFFD, "R2", "high read", mem_addr, 16'hFFFD);
        tick();
        chk(pc_load == 1 && pc_value == 16'hC53A, "R2", "pc_value", pc_value, 16'hC53A);
        tick();
        chk(pc_load == 0 && step_enable == 1, "R2", "load once", pc_load, 0);
        ticks(2);

        // R3 combined interrupt with two-edge delay
        irq_a_n = 0; tick();
        chk(irq == 0, "R3", "irq after one edge", irq, 0);
        tick();
        chk(irq == 1, "R3", "irq after two edges", irq, 1);
        irq_a_n = 1; irq_b_n = 0; ticks(3);
        chk(irq == 1, "R3", "irq from b", irq, 1);
        irq_b_n = 1; ticks(2);
        chk(irq == 0, "R3", "irq released", irq, 0);

        // R8 ready passthrough
        rdy_pin = 0; #1;
        chk(rdy == 0, "R8", "rdy low", rdy, 0);
        tick(); rdy_pin = 1;

        // R4 / R5 edge latch
        nmi_n = 0; tick();
        chk(nmi_latch == 0, "R4", "nmi before edge seen", nmi_latch, 0);
        tick();
        chk(nmi_latch == 1, "R4", "nmi latched", nmi_latch, 1);
        ticks(3);
        chk(nmi_latch == 1, "R5", "nmi held", nmi_latch, 1);
        nmi_ack = 1; tick(); nmi_ack = 0;
        chk(nmi_latch == 0, "R5", "nmi cleared", nmi_latch, 0);
        ticks(3);
        chk(nmi_latch == 0, "R5", "level does not retrigger", nmi_latch, 0);
        nmi_n = 1; ticks(2);
        nmi_n = 0; nmi_ack = 1; ticks(2);
        chk(nmi_latch == 1, "R5", "set wins over ack", nmi_latch, 1);
        nmi_ack = 1; tick(); nmi_ack = 0; nmi_n = 1; ticks(3);

        // R6 / R7 bus withheld
        aec = 0; #1;
        chk(step_enable == 0, "R6", "no step without bus", step_enable, 0);
        ticks(5);
        chk(lag_count == 5, "R7", "lag count", lag_count, 5);

        // R10 pulse entirely inside withheld window
        nmi_n = 0; ticks(2); nmi_n = 1; ticks(3);
        aec = 1; ticks(3);
        chk(nmi_latch == 0, "R10", "hidden pulse ignored", nmi_latch, 0);
        chk(lag_count == 10, "R7", "lag holds with bus", lag_count, 10);

        // R4 edge deferred until bus granted
        aec = 0; nmi_n = 0; ticks(3);
        chk(nmi_latch == 0, "R4", "no latch while withheld", nmi_latch, 0);
        aec = 1; tick();
        chk(nmi_latch == 1, "R4", "latched on grant", nmi_latch, 1);
        nmi_ack = 1; tick(); nmi_ack = 0; nmi_n = 1; ticks(2);

        // R9 overflow pulses
        so_req = 1; tick(); so_req = 0;
        chk(set_overflow == 0, "R9", "not yet", set_overflow, 0);
        tick();
        chk(set_overflow == 1, "R9", "pulse", set_overflow, 1);
        tick();
        chk(set_overflow == 0, "R9", "single pulse", set_overflow, 0);
        so_req = 1; ticks(3); so_req = 0; ticks(3);

        // R1 mid-run reset restarts fetch with new vector
        vlo = 8'h10; vhi = 8'h80;
        rst = 1; tick();
        chk(lag_count == 0 && nmi_latch == 0 && step_enable == 0, "R1", "mid-run reset", lag_count, 0);
        rst = 0; ticks(2);
        chk(pc_load == 1 && pc_value == 16'h8010, "R2", "new vector", pc_value, 16'h8010);

        // mixed stimulus against the model
        for (int i = 0; i < 1500; i++) begin
            irq_a_n = ($urandom % 4) != 0;
            irq_b_n = ($urandom % 5) != 0;
            nmi_n   = ($urandom % 3) != 0;
            nmi_ack = ($urandom % 6) == 0;
            aec     = ($urandom % 4) != 0;
            rdy_pin = ($urandom % 2) != 0;
            so_req  = ($urandom % 5) == 0;
            rst     = ($urandom % 300) == 0;
            if (rst) begin vlo = 8'($urandom); vhi = 8'($urandom); end
            tick();
        end
        rst = 0;
        ticks(4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule